// File: doc/BRIEF.md
# Ripple-Chained Integer ALU

This block is a purely combinational integer unit for a 32-bit datapath. Two operands and a four-bit operation code come in. The unit returns a result word and three status bits: a zero indicator, a signed-overflow indicator and the carry from the top of the adder chain. It has no registers and no clock. A pipeline stage or a branch comparator places it between its own flops.

The datapath is a row of identical one-bit cells joined by a rippling carry, with a different cell at the top. Each cell can complement either of its operand bits. It has a full adder and a four-way output selector whose fourth input is a "less" line. Subtraction complements the second operand and injects a carry of one at the bottom. The complement of OR is made by complementing both operands and taking the AND path.

Signed less-than is formed by the top cell. It takes the sign of the difference, corrected for overflow, and routes it back to the less line of bit 0. The less lines of all other bits are held low.

Top module: `alu32_sliced`

## Requirements
- R1: Code 0000 gives the bitwise AND of the two operands.
- R2: Code 0001 gives the bitwise OR of the two operands.
- R3: Code 0010 gives the sum of the operands modulo 2^32.
- R4: Code 0110 gives the first operand minus the second operand modulo 2^32.
- R5: Code 0111 gives 1 when the first operand is less than the second as signed two's-complement numbers, and 0 otherwise. All bits above bit 0 are 0. The answer stays correct when the internal subtraction overflows.
- R6: Code 1100 gives the bitwise complement of (first operand OR second operand).
- R7: For every code, the zero output is 1 exactly when all 32 result bits are 0.
- R8: For the six listed codes, the carry and overflow outputs describe the adder chain sum `ae + be + c0`. Here `ae` is the first operand, complemented when code bit 3 is 1. `be` is the second operand, complemented when code bit 2 is 1. `c0` equals code bit 2. Carry is bit 32 of that unsigned sum. Overflow is 1 when `ae` and `be` share a sign bit that differs from bit 31 of the sum.
- R9: Any code not listed above gives a result of 0, carry 0 and overflow 0, so the zero output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand |
| ctrl_i | input | 4 | Operation code |
| result_o | output | 32 | Result word |
| zero_o | output | 1 | High when the result is all zeros |
| overflow_o | output | 1 | Signed overflow of the adder chain |
| carry_o | output | 1 | Carry out of the top cell |

## Verification
Every code is applied to the operand values 0, all-ones, the largest positive number and the most negative number, in every pairing. These pairings separate a carry from a signed overflow. They also show whether the less-than answer is corrected for overflow: the most negative number minus the largest positive number wraps around, yet less-than must still report 1. Equal operands under subtraction test the zero flag. A sweep over all sixteen codes shows that unlisted codes stay quiet. Random operand pairs, with sign bits mixed, cover ripple patterns across the whole chain.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

  localparam int CTRL_W = 4;

  typedef enum logic [CTRL_W-1:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111,
    OP_NOR = 4'b1100
  } alu_op_e;

  typedef enum logic [1:0] {
    PICK_AND  = 2'd0,
    PICK_OR   = 2'd1,
    PICK_SUM  = 2'd2,
    PICK_LESS = 2'd3
  } pick_e;

  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (x & ci) | (y & ci);
  endfunction

  function automatic logic op_is_listed(input logic [CTRL_W-1:0] code);
    case (code)
      OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT, OP_NOR: return 1'b1;
      default:                                       return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu32_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       ainv_i,
  input  logic       bneg_i,
  input  logic       cin_i,
  input  logic       less_i,
  input  logic [1:0] pick_i,
  output logic       res_o,
  output logic       sum_o,
  output logic       cout_o
);

  logic a_eff;
  logic b_eff;

  assign a_eff  = ainv_i ? ~a_i : a_i;
  assign b_eff  = bneg_i ? ~b_i : b_i;
  assign sum_o  = fa_sum(a_eff, b_eff, cin_i);
  assign cout_o = fa_carry(a_eff, b_eff, cin_i);

  always_comb begin
    case (pick_e'(pick_i))
      PICK_AND:  res_o = a_eff & b_eff;
      PICK_OR:   res_o = a_eff | b_eff;
      PICK_SUM:  res_o = sum_o;
      default:   res_o = less_i;
    endcase
  end

endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
  import alu32_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       ainv_i,
  input  logic       bneg_i,
  input  logic       cin_i,
  input  logic       less_i,
  input  logic [1:0] pick_i,
  output logic       res_o,
  output logic       cout_o,
  output logic       set_o,
  output logic       ovf_o
);

  logic sum_w;

  alu_bit_slice u_core (
    .a_i    (a_i),
    .b_i    (b_i),
    .ainv_i (ainv_i),
    .bneg_i (bneg_i),
    .cin_i  (cin_i),
    .less_i (less_i),
    .pick_i (pick_i),
    .res_o  (res_o),
    .sum_o  (sum_w),
    .cout_o (cout_o)
  );

  // overflow only detectable at the top: carry in and carry out disagree
  assign ovf_o = cin_i ^ cout_o;
  // sign of the difference, corrected when the subtraction wrapped
  assign set_o = sum_w ^ ovf_o;

  logic a_eff_chk;
  logic b_eff_chk;
  assign a_eff_chk = ainv_i ? ~a_i : a_i;
  assign b_eff_chk = bneg_i ? ~b_i : b_i;

  always_comb begin
    // R8
    msb_overflow_chk: assert (ovf_o == ((a_eff_chk == b_eff_chk) && (sum_w != a_eff_chk)));
  end

endmodule

// File: rtl/alu32_sliced.sv
module alu32_sliced
  import alu32_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]  op_a_i,
  input  logic [WIDTH-1:0]  op_b_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [WIDTH-1:0]  result_o,
  output logic              zero_o,
  output logic              overflow_o,
  output logic              carry_o
);

  localparam int MSB = WIDTH - 1;

  logic             ainv_w;
  logic             bneg_w;
  logic [1:0]       pick_w;
  logic             listed_w;
  logic             set_w;
  logic             ovf_w;
  logic [WIDTH:0]   carry_w;
  logic [WIDTH-1:0] chain_res_w;
  logic [WIDTH-1:0] sum_unused_w;

  assign ainv_w     = ctrl_i[3];
  assign bneg_w     = ctrl_i[2];
  assign pick_w     = ctrl_i[1:0];
  assign listed_w   = op_is_listed(ctrl_i);
  assign carry_w[0] = bneg_w;
  assign sum_unused_w[MSB] = 1'b0;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
    if (gi == MSB) begin : g_top
      alu_msb_slice u_slice (
        .a_i    (op_a_i[gi]),
        .b_i    (op_b_i[gi]),
        .ainv_i (ainv_w),
        .bneg_i (bneg_w),
        .cin_i  (carry_w[gi]),
        .less_i (1'b0),
        .pick_i (pick_w),
        .res_o  (chain_res_w[gi]),
        .cout_o (carry_w[gi+1]),
        .set_o  (set_w),
        .ovf_o  (ovf_w)
      );
    end else begin : g_low
      alu_bit_slice u_slice (
        .a_i    (op_a_i[gi]),
        .b_i    (op_b_i[gi]),
        .ainv_i (ainv_w),
        .bneg_i (bneg_w),
        .cin_i  (carry_w[gi]),
        .less_i ((gi == 0) ? set_w : 1'b0),
        .pick_i (pick_w),
        .res_o  (chain_res_w[gi]),
        .sum_o  (sum_unused_w[gi]),
        .cout_o (carry_w[gi+1])
      );
    end
  end

  assign result_o   = listed_w ? chain_res_w : '0;
  assign overflow_o = listed_w & ovf_w;
  assign carry_o    = listed_w & carry_w[WIDTH];
  assign zero_o     = ~|result_o;

  logic unused_ok;
  assign unused_ok = ^sum_unused_w;

  always_comb begin
    if (ctrl_i == OP_ADD) begin
      // R3
      add_result_chk: assert (result_o == op_a_i + op_b_i);
    end
    if (ctrl_i == OP_NOR) begin
      // R6
      nor_result_chk: assert (result_o == ~(op_a_i | op_b_i));
    end
    if (ctrl_i == OP_SLT) begin
      // R5
      slt_upper_chk: assert (result_o[WIDTH-1:1] == '0);
    end
    if (!op_is_listed(ctrl_i)) begin
      // R9
      unlisted_quiet_chk: assert (result_o == '0 && !overflow_o && !carry_o);
    end
    if (ctrl_i == OP_SUB && op_a_i == op_b_i) begin
      // R7
      equal_sub_zero_chk: assert (zero_o);
    end
  end

endmodule

// File: tb/alu32_sliced_tb.sv
module alu32_sliced_tb_top;

  logic        clk;
  logic [31:0] a, b;
  logic [3:0]  ctrl;
  logic [31:0] result;
  logic        zero, ovf, cout;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  alu32_sliced dut_i (
    .op_a_i     (a),
    .op_b_i     (b),
    .ctrl_i     (ctrl),
    .result_o   (result),
    .zero_o     (zero),
    .overflow_o (ovf),
    .carry_o    (cout)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  localparam int NVEC = 12;
  localparam logic [67:0] VEC [NVEC] = '{
    {32'h0000_00F0, 32'h0000_0F0F, 4'b0000},
    {32'hA5A5_0000, 32'h0000_5A5A, 4'b0001},
    {32'hFFFF_FFFF, 32'h0000_0001, 4'b0010},
    {32'h7FFF_FFFF, 32'h0000_0001, 4'b0010},
    {32'h0000_0005, 32'h0000_0007, 4'b0110},
    {32'h8000_0000, 32'h0000_0001, 4'b0110},
    {32'h8000_0000, 32'h7FFF_FFFF, 4'b0111},
    {32'h7FFF_FFFF, 32'h8000_0000, 4'b0111},
    {32'hFFFF_FFFE, 32'hFFFF_FFFF, 4'b0111},
    {32'h0F0F_0000, 32'h00F0_F000, 4'b1100},
    {32'h1234_5678, 32'h1234_5678, 4'b0110},
    {32'h1234_5678, 32'h9ABC_DEF0, 4'b1011}
  };

  localparam logic [31:0] CORNER [4] = '{32'h0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};
  localparam logic [3:0]  CODES  [6] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};

  function automatic string res_tag(input logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1100: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic model(input logic [31:0] x, input logic [31:0] y, input logic [3:0] c,
                       output logic [31:0] r, output logic z, output logic v, output logic co);
    logic [31:0] xe, ye, s;
    logic        listed;
    xe = c[3] ? ~x : x;
    ye = c[2] ? ~y : y;
    {co, s} = {1'b0, xe} + {1'b0, ye} + {32'd0, c[2]};
    v = (xe[31] == ye[31]) && (s[31] != xe[31]);
    listed = 1'b1;
    case (c)
      4'b0000: r = x & y;
      4'b0001: r = x | y;
      4'b0010: r = x + y;
      4'b0110: r = x - y;
      4'b0111: r = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'b1100: r = ~(x | y);
      default: begin r = '0; listed = 1'b0; end
    endcase
    if (!listed) begin v = 1'b0; co = 1'b0; end
    z = (r == '0);
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: a=%h b=%h ctrl=%b actual=%h expected=%h", tag, what, a, b, ctrl, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic [3:0] c);
    logic [31:0] er;
    logic ez, ev, ec;
    @(negedge clk);
    a = x; b = y; ctrl = c;
    model(x, y, c, er, ez, ev, ec);
    @(posedge clk);
    #1;
    check(res_tag(c), "result", result, er);
    check("R7", "zero", {31'd0, zero}, {31'd0, ez});
    check(c inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100} ? "R8" : "R9",
          "overflow", {31'd0, ovf}, {31'd0, ev});
    check(c inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100} ? "R8" : "R9",
          "carry", {31'd0, cout}, {31'd0, ec});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    a = '0; b = '0; ctrl = 4'b0000;
    // initial state: zero operands under AND (R1, R7)
    @(posedge clk); #1;
    check("R1", "initial result", result, 32'd0);
    check("R7", "initial zero", {31'd0, zero}, 32'd1);

    for (int i = 0; i < NVEC; i++)
      apply(VEC[i][67:36], VEC[i][35:4], VEC[i][3:0]);

    // corner operand pairs under every listed code (R1..R8)
    for (int ia = 0; ia < 4; ia++)
      for (int ib = 0; ib < 4; ib++)
        for (int ic = 0; ic < 6; ic++)
          apply(CORNER[ia], CORNER[ib], CODES[ic]);

    // R9: sweep of all codes with a fixed operand pair
    for (int c = 0; c < 16; c++)
      apply(32'hDEAD_BEEF, 32'h1357_9BDF, c[3:0]);

    // R7: equal operands under subtract give zero
    apply(32'h8000_0000, 32'h8000_0000, 4'b0110);
    apply(32'h0000_0001, 32'h0000_0001, 4'b0110);

    // R5: slt with the most negative number minus the largest positive one
    apply(32'h8000_0000, 32'h7FFF_FFFF, 4'b0111);

    for (int k = 0; k < 200; k++)
      apply($urandom, $urandom, CODES[k % 6]);

    finish_run();
  end

endmodule